// File: doc/BRIEF.md
# PC Card Socket Bus Bridge

The bridge is a bus slave that sits between a processor memory bus and a single removable PC Card / CompactFlash slot. It owns a 256 MB address window and splits it into four 64 MB quarters. Three of these quarters select a card space: I/O, attribute memory and common memory. The fourth quarter is a reserved hole. An access to a card space is forwarded to a simple request/response card port, together with a 2-bit space code and the 26-bit offset inside that space. The host transfer completes only when the card returns its response.

The bridge also tracks whether a card is present. Insert and eject requests arrive as single-cycle pulses and are acknowledged with an ok/error status. A successful insert raises the card-detect interrupt and notifies the card. A successful eject notifies the card and lowers both the card-detect and the card interrupt. While a card is present, its interrupt line is passed through to the host interrupt output.

When the slot is empty, and for any access to the reserved hole, the transfer still completes. Reads return zero and writes are dropped, so the host bus never stalls.

Top module: `pccard_bridge`

## Requirements
- R1: An access at window offset 0x000_0000..0x3FF_FFFF with a card present is forwarded with space code 0 (I/O) and offset equal to address bits [25:0]; write flag and write data are forwarded unchanged.
- R2: Offsets 0x800_0000..0xBFF_FFFF are forwarded with space code 1 (attribute) and 0xC00_0000..0xFFF_FFFF with space code 2 (common), offset equal to address bits [25:0].
- R3: An access to the reserved quarter 0x400_0000..0x7FF_FFFF raises no card request and completes one cycle after acceptance with read data zero.
- R4: With the slot empty, no access raises a card request; every access completes one cycle after acceptance with read data zero.
- R5: A forwarded access holds card_req_o high with stable space and offset until card_rsp_i is seen. host_rsp_o pulses in the following cycle, with read data equal to card_rdata_i for reads and zero for writes. host_ready_o is low from acceptance until the response cycle ends.
- R6: An insert on an empty slot, in the cycle after the request, raises present_o and cd_irq_o, pulses attach_o for one cycle, and acknowledges with ctl_err_o low.
- R7: An insert while a card is present acknowledges with ctl_err_o high and changes neither present_o nor cd_irq_o; attach_o stays low.
- R8: An eject on an empty slot acknowledges with ctl_err_o high, and present_o stays low.
- R9: A successful eject, in the cycle after the request, pulses detach_o, lowers present_o and cd_irq_o, and forces host_irq_o low even when the card interrupt is still high.
- R10: While a card is present, host_irq_o follows card_irq_i one cycle later. While the slot is empty, card_irq_i is ignored. With HOST_IRQ_EN = 0, host_irq_o is held low.
- R11: An eject while a card access is outstanding drops card_req_o within one cycle after present_o falls, and completes the host transfer with read data zero.
- R12: When insert and eject are requested in the same cycle, the insert is processed and the eject is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_valid_i | input | 1 | Host transfer request, accepted when host_ready_o is high |
| host_we_i | input | 1 | Host transfer is a write |
| host_addr_i | input | ADDR_W | Offset inside the bridge window |
| host_wdata_i | input | DATA_W | Host write data |
| host_ready_o | output | 1 | Bridge idle and able to accept a transfer |
| host_rsp_o | output | 1 | One-cycle pulse: transfer complete |
| host_rdata_o | output | DATA_W | Read data, valid with host_rsp_o |
| card_req_o | output | 1 | Card access outstanding |
| card_we_o | output | 1 | Card access is a write |
| card_space_o | output | 2 | Space code: 0 I/O, 1 attribute, 2 common |
| card_ofs_o | output | ADDR_W-2 | Offset inside the selected space |
| card_wdata_o | output | DATA_W | Card write data |
| card_rsp_i | input | 1 | Card response valid |
| card_rdata_i | input | DATA_W | Card read data |
| insert_i | input | 1 | Card insert request pulse |
| eject_i | input | 1 | Card eject request pulse |
| ctl_ack_o | output | 1 | Slot request acknowledged |
| ctl_err_o | output | 1 | Slot request refused, valid with ctl_ack_o |
| attach_o | output | 1 | Pulse notifying the card it was attached |
| detach_o | output | 1 | Pulse notifying the card it is being removed |
| present_o | output | 1 | Card present |
| cd_irq_o | output | 1 | Card-detect interrupt |
| card_irq_i | input | 1 | Interrupt level from the card |
| host_irq_o | output | 1 | Card interrupt toward the host |

## Verification
The bench builds the bridge with its default 28-bit window, 32-bit data and the host interrupt enabled. With these values it can reach the first and last byte of every 64 MB quarter, including the edges of the reserved hole. A second copy is built with HOST_IRQ_EN = 0 and driven by the same stimulus, so the disconnected-interrupt variant is compared against the connected one in the same cycles. Directed sequences cover refused inserts and ejects, simultaneous requests, and an eject that arrives while the card is still holding off a response.

// File: rtl/pccard_pkg.sv
package pccard_pkg;

  typedef enum logic [1:0] {
    SP_IO     = 2'd0,
    SP_ATTR   = 2'd1,
    SP_COMMON = 2'd2,
    SP_NONE   = 2'd3
  } space_e;

  typedef enum logic [1:0] {
    XF_IDLE = 2'd0,
    XF_WAIT = 2'd1,
    XF_DONE = 2'd2
  } xfer_state_e;

endpackage

// File: rtl/pccard_decode.sv
module pccard_decode
  import pccard_pkg::*;
#(
  parameter int ADDR_W = 28,
  localparam int OFS_W = ADDR_W - 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output space_e            space_o,
  output logic [OFS_W-1:0]  ofs_o
);

  logic [1:0] quarter;
  assign quarter = addr_i[ADDR_W-1 -: 2];
  assign ofs_o   = addr_i[OFS_W-1:0];

  always_comb begin
    unique case (quarter)
      2'b00:   space_o = SP_IO;
      2'b10:   space_o = SP_ATTR;
      2'b11:   space_o = SP_COMMON;
      default: space_o = SP_NONE;  // reserved hole
    endcase
  end

  assign hit_o = (space_o != SP_NONE);

endmodule

// File: rtl/pccard_slot.sv
module pccard_slot #(
  parameter bit HOST_IRQ_EN = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic insert_i,
  input  logic eject_i,
  input  logic card_irq_i,
  output logic present_o,
  output logic cd_irq_o,
  output logic ack_o,
  output logic err_o,
  output logic attach_o,
  output logic detach_o,
  output logic host_irq_o
);

  logic present_q, cd_q, ack_q, err_q, att_q, det_q;
  logic do_eject;

  // insert wins over a simultaneous eject
  assign do_eject = eject_i && !insert_i && present_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      present_q <= 1'b0;
      cd_q      <= 1'b0;
      ack_q     <= 1'b0;
      err_q     <= 1'b0;
      att_q     <= 1'b0;
      det_q     <= 1'b0;
    end else begin
      ack_q <= 1'b0;
      err_q <= 1'b0;
      att_q <= 1'b0;
      det_q <= 1'b0;
      if (insert_i) begin
        ack_q <= 1'b1;
        if (present_q) begin
          err_q <= 1'b1;
        end else begin
          present_q <= 1'b1;
          cd_q      <= 1'b1;
          att_q     <= 1'b1;
        end
      end else if (eject_i) begin
        ack_q <= 1'b1;
        if (!present_q) begin
          err_q <= 1'b1;
        end else begin
          present_q <= 1'b0;
          cd_q      <= 1'b0;
          det_q     <= 1'b1;
        end
      end
    end
  end

  generate
    if (HOST_IRQ_EN) begin : g_irq
      logic irq_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)        irq_q <= 1'b0;
        else if (do_eject)  irq_q <= 1'b0;
        else if (present_q) irq_q <= card_irq_i;
        else                irq_q <= 1'b0;
      end
      assign host_irq_o = irq_q;
    end else begin : g_no_irq
      logic unused_irq;
      assign unused_irq = card_irq_i;
      assign host_irq_o = 1'b0;
    end
  endgenerate

  assign present_o = present_q;
  assign cd_irq_o  = cd_q;
  assign ack_o     = ack_q;
  assign err_o     = err_q;
  assign attach_o  = att_q;
  assign detach_o  = det_q;

endmodule

// File: rtl/pccard_xfer.sv
module pccard_xfer
  import pccard_pkg::*;
#(
  parameter int ADDR_W = 28,
  parameter int DATA_W = 32,
  localparam int OFS_W = ADDR_W - 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_valid_i,
  input  logic              host_we_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  input  logic              hit_i,
  input  space_e            space_i,
  input  logic [OFS_W-1:0]  ofs_i,
  input  logic              present_i,
  output logic              host_ready_o,
  output logic              host_rsp_o,
  output logic [DATA_W-1:0] host_rdata_o,
  output logic              card_req_o,
  output logic              card_we_o,
  output logic [1:0]        card_space_o,
  output logic [OFS_W-1:0]  card_ofs_o,
  output logic [DATA_W-1:0] card_wdata_o,
  input  logic              card_rsp_i,
  input  logic [DATA_W-1:0] card_rdata_i
);

  xfer_state_e       state_q;
  logic              we_q;
  space_e            space_q;
  logic [OFS_W-1:0]  ofs_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= XF_IDLE;
      we_q    <= 1'b0;
      space_q <= SP_NONE;
      ofs_q   <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      unique case (state_q)
        XF_IDLE: if (host_valid_i) begin
          we_q    <= host_we_i;
          space_q <= space_i;
          ofs_q   <= ofs_i;
          wdata_q <= host_wdata_i;
          rdata_q <= '0;
          state_q <= (hit_i && present_i) ? XF_WAIT : XF_DONE;
        end
        XF_WAIT: begin
          if (!present_i) begin
            rdata_q <= '0;        // card pulled mid-access
            state_q <= XF_DONE;
          end else if (card_rsp_i) begin
            rdata_q <= we_q ? '0 : card_rdata_i;
            state_q <= XF_DONE;
          end
        end
        XF_DONE: state_q <= XF_IDLE;
        default: state_q <= XF_IDLE;
      endcase
    end
  end

  assign host_ready_o = (state_q == XF_IDLE);
  assign host_rsp_o   = (state_q == XF_DONE);
  assign host_rdata_o = rdata_q;
  assign card_req_o   = (state_q == XF_WAIT);
  assign card_we_o    = we_q;
  assign card_space_o = space_q;
  assign card_ofs_o   = ofs_q;
  assign card_wdata_o = wdata_q;

endmodule

// File: rtl/pccard_bridge.sv
module pccard_bridge
  import pccard_pkg::*;
#(
  parameter int ADDR_W      = 28,
  parameter int DATA_W      = 32,
  parameter bit HOST_IRQ_EN = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_valid_i,
  input  logic              host_we_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  output logic              host_ready_o,
  output logic              host_rsp_o,
  output logic [DATA_W-1:0] host_rdata_o,
  output logic              card_req_o,
  output logic              card_we_o,
  output logic [1:0]        card_space_o,
  output logic [ADDR_W-3:0] card_ofs_o,
  output logic [DATA_W-1:0] card_wdata_o,
  input  logic              card_rsp_i,
  input  logic [DATA_W-1:0] card_rdata_i,
  input  logic              insert_i,
  input  logic              eject_i,
  output logic              ctl_ack_o,
  output logic              ctl_err_o,
  output logic              attach_o,
  output logic              detach_o,
  output logic              present_o,
  output logic              cd_irq_o,
  input  logic              card_irq_i,
  output logic              host_irq_o
);

  localparam int OFS_W = ADDR_W - 2;

  logic             dec_hit;
  space_e           dec_space;
  logic [OFS_W-1:0] dec_ofs;
  logic             present;

  pccard_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr_i  (host_addr_i),
    .hit_o   (dec_hit),
    .space_o (dec_space),
    .ofs_o   (dec_ofs)
  );

  pccard_slot #(.HOST_IRQ_EN(HOST_IRQ_EN)) u_slot (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .insert_i   (insert_i),
    .eject_i    (eject_i),
    .card_irq_i (card_irq_i),
    .present_o  (present),
    .cd_irq_o   (cd_irq_o),
    .ack_o      (ctl_ack_o),
    .err_o      (ctl_err_o),
    .attach_o   (attach_o),
    .detach_o   (detach_o),
    .host_irq_o (host_irq_o)
  );

  pccard_xfer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_xfer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .host_valid_i (host_valid_i),
    .host_we_i    (host_we_i),
    .host_wdata_i (host_wdata_i),
    .hit_i        (dec_hit),
    .space_i      (dec_space),
    .ofs_i        (dec_ofs),
    .present_i    (present),
    .host_ready_o (host_ready_o),
    .host_rsp_o   (host_rsp_o),
    .host_rdata_o (host_rdata_o),
    .card_req_o   (card_req_o),
    .card_we_o    (card_we_o),
    .card_space_o (card_space_o),
    .card_ofs_o   (card_ofs_o),
    .card_wdata_o (card_wdata_o),
    .card_rsp_i   (card_rsp_i),
    .card_rdata_i (card_rdata_i)
  );

  assign present_o = present;

endmodule

// File: rtl/pccard_bridge_chk.sv
module pccard_bridge_chk #(
  parameter int ADDR_W = 28
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              host_ready_o,
  input logic              host_rsp_o,
  input logic              card_req_o,
  input logic              card_rsp_i,
  input logic [1:0]        card_space_o,
  input logic [ADDR_W-3:0] card_ofs_o,
  input logic              present_o,
  input logic              cd_irq_o,
  input logic              host_irq_o,
  input logic              ctl_ack_o,
  input logic              ctl_err_o,
  input logic              attach_o,
  input logic              detach_o
);

  assert_space_code_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    card_req_o |-> card_space_o != 2'd3);

  assert_empty_no_irq_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !present_o |-> !host_irq_o);

  assert_req_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (card_req_o && !card_rsp_i && present_o) |=> (card_req_o && $stable(card_ofs_o)));

  assert_rsp_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_rsp_o |-> !host_ready_o && !card_req_o);

  assert_abort_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (card_req_o && !present_o) |=> (!card_req_o && host_rsp_o));

  assert_insert_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(present_o) |-> (cd_irq_o && attach_o && ctl_ack_o && !ctl_err_o));

  assert_refused_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_ack_o && ctl_err_o) |-> ($stable(present_o) && !attach_o && !detach_o));

  assert_eject_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(present_o) |-> (detach_o && !cd_irq_o && !host_irq_o));

endmodule

bind pccard_bridge pccard_bridge_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/pccard_bridge_tb_top.sv
module pccard_bridge_tb_top;

  localparam int ADDR_W = 28;
  localparam int DATA_W = 32;
  localparam int OFS_W  = ADDR_W - 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic              host_valid_i = 0, host_we_i = 0;
  logic [ADDR_W-1:0] host_addr_i = '0;
  logic [DATA_W-1:0] host_wdata_i = '0, card_rdata_i = '0;
  logic              card_rsp_i = 0, insert_i = 0, eject_i = 0, card_irq_i = 0;

  logic              host_ready_o, host_rsp_o, card_req_o, card_we_o;
  logic [DATA_W-1:0] host_rdata_o, card_wdata_o;
  logic [1:0]        card_space_o;
  logic [OFS_W-1:0]  card_ofs_o;
  logic              ctl_ack_o, ctl_err_o, attach_o, detach_o, present_o, cd_irq_o, host_irq_o;

  logic              n_ready, n_rsp, n_req, n_we, n_ack, n_err, n_att, n_det, n_pres, n_cd, n_irq;
  logic [DATA_W-1:0] n_rdata, n_wdata;
  logic [1:0]        n_space;
  logic [OFS_W-1:0]  n_ofs;

  pccard_bridge #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .HOST_IRQ_EN(1'b1)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .host_valid_i, .host_we_i, .host_addr_i, .host_wdata_i,
    .host_ready_o, .host_rsp_o, .host_rdata_o,
    .card_req_o, .card_we_o, .card_space_o, .card_ofs_o, .card_wdata_o,
    .card_rsp_i, .card_rdata_i, .insert_i, .eject_i,
    .ctl_ack_o, .ctl_err_o, .attach_o, .detach_o, .present_o, .cd_irq_o,
    .card_irq_i, .host_irq_o
  );

  pccard_bridge #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .HOST_IRQ_EN(1'b0)) dut_nirq_i (
    .clk_i(clk), .rst_ni(rst_n),
    .host_valid_i, .host_we_i, .host_addr_i, .host_wdata_i,
    .host_ready_o(n_ready), .host_rsp_o(n_rsp), .host_rdata_o(n_rdata),
    .card_req_o(n_req), .card_we_o(n_we), .card_space_o(n_space), .card_ofs_o(n_ofs),
    .card_wdata_o(n_wdata), .card_rsp_i, .card_rdata_i, .insert_i, .eject_i,
    .ctl_ack_o(n_ack), .ctl_err_o(n_err), .attach_o(n_att), .detach_o(n_det),
    .present_o(n_pres), .cd_irq_o(n_cd), .card_irq_i, .host_irq_o(n_irq)
  );

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit finished = 0;

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  typedef struct packed {
    logic              we;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
    logic [DATA_W-1:0] crd;
    logic              fwd;
    logic [1:0]        space;
    logic [OFS_W-1:0]  ofs;
    logic [DATA_W-1:0] rdata;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 28'h000_0010, 32'h0,         32'hA5A5_0001, 1'b1, 2'd0, 26'h000_0010, 32'hA5A5_0001},
    '{1'b1, 28'h3FF_FFFC, 32'h0000_1234, 32'h9999_9999, 1'b1, 2'd0, 26'h3FF_FFFC, 32'h0},
    '{1'b0, 28'h400_0000, 32'h0,         32'h1111_1111, 1'b0, 2'd0, 26'h0,        32'h0},
    '{1'b1, 28'h7FF_FFFF, 32'hCAFE_0000, 32'h2222_2222, 1'b0, 2'd0, 26'h0,        32'h0},
    '{1'b0, 28'h800_0000, 32'h0,         32'hDEAD_BEEF, 1'b1, 2'd1, 26'h000_0000, 32'hDEAD_BEEF},
    '{1'b1, 28'hBFF_FFFF, 32'h00C0_FFEE, 32'h3333_3333, 1'b1, 2'd1, 26'h3FF_FFFF, 32'h0},
    '{1'b0, 28'hC00_0004, 32'h0,         32'h0BAD_F00D, 1'b1, 2'd2, 26'h000_0004, 32'h0BAD_F00D},
    '{1'b0, 28'hFFF_FFF0, 32'h0,         32'h5555_AAAA, 1'b1, 2'd2, 26'h3FF_FFF0, 32'h5555_AAAA}
  };

  // one host transfer; the bench plays the card, answering on the 2nd request cycle
  task automatic run_xfer(input logic we, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] wd,
                          input logic [DATA_W-1:0] crd, input bit eject_mid,
                          output bit fwd, output logic [1:0] sp, output logic [OFS_W-1:0] ofs,
                          output logic cwe, output logic [DATA_W-1:0] cwd,
                          output logic [DATA_W-1:0] rd, output logic req_at_done,
                          output logic ready_busy);
    int n = 0;
    bit done = 0;
    fwd = 0; sp = '0; ofs = '0; cwe = 0; cwd = '0; rd = '0; req_at_done = 0; ready_busy = 0;
    @(negedge clk);
    host_valid_i = 1; host_we_i = we; host_addr_i = a; host_wdata_i = wd; card_rdata_i = crd;
    @(negedge clk);
    host_valid_i = 0;
    for (int i = 0; i < 40 && !done; i++) begin
      card_rsp_i = 0; eject_i = 0;
      if (host_rsp_o) begin
        done = 1; rd = host_rdata_o; req_at_done = card_req_o;
      end else begin
        if (card_req_o) begin
          if (!fwd) begin
            sp = card_space_o; ofs = card_ofs_o; cwe = card_we_o; cwd = card_wdata_o;
            ready_busy = host_ready_o;
          end
          fwd = 1; n++;
          if (n == 2) begin
            if (eject_mid) eject_i = 1; else card_rsp_i = 1;
          end
        end
        @(negedge clk);
      end
    end
    card_rsp_i = 0; eject_i = 0;
    if (!done) check("R5", "transfer never completed", 0, 1);
  endtask

  task automatic do_ctl(input logic ins, input logic ej);
    @(negedge clk);
    insert_i = ins; eject_i = ej;
    @(negedge clk);
    insert_i = 0; eject_i = 0;
  endtask

  initial begin : watchdog
    while (!finished && cycles < 20000) begin
      @(posedge clk);
      cycles++;
    end
    if (!finished) begin
      check("ALL", "watchdog expired", 0, 1);
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin : main
    bit fwd;
    logic [1:0] sp;
    logic [OFS_W-1:0] ofs;
    logic cwe, rqd, rdyb;
    logic [DATA_W-1:0] cwd, rd;

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state
    check("R4", "reset present", present_o, 0);
    check("R6", "reset cd_irq", cd_irq_o, 0);
    check("R10", "reset host_irq", host_irq_o, 0);
    check("R5", "reset ready", host_ready_o, 1);
    check("R5", "reset card_req", card_req_o, 0);

    // empty slot
    run_xfer(0, 28'hC00_0000, 0, 32'hFFFF_FFFF, 0, fwd, sp, ofs, cwe, cwd, rd, rqd, rdyb);
    check("R4", "empty read forwarded", fwd, 0);
    check("R4", "empty read data", rd, 0);
    run_xfer(1, 28'h000_0100, 32'h1234_5678, 0, 0, fwd, sp, ofs, cwe, cwd, rd, rqd, rdyb);
    check("R4", "empty write forwarded", fwd, 0);

    card_irq_i = 1;
    repeat (2) @(negedge clk);
    check("R10", "irq ignored while empty", host_irq_o, 0);
    card_irq_i = 0;

    do_ctl(0, 1);
    check("R8", "eject empty ack", ctl_ack_o, 1);
    check("R8", "eject empty err", ctl_err_o, 1);
    check("R8", "eject empty present", present_o, 0);

    do_ctl(1, 0);
    check("R6", "insert ack", ctl_ack_o, 1);
    check("R6", "insert err", ctl_err_o, 0);
    check("R6", "insert present", present_o, 1);
    check("R6", "insert cd_irq", cd_irq_o, 1);
    check("R6", "insert attach", attach_o, 1);
    @(negedge clk);
    check("R6", "attach one cycle", attach_o, 0);

    do_ctl(1, 0);
    check("R7", "second insert err", ctl_err_o, 1);
    check("R7", "second insert present", present_o, 1);
    check("R7", "second insert cd_irq", cd_irq_o, 1);
    check("R7", "second insert attach", attach_o, 0);

    // vector table with a card present
    for (int v = 0; v < NV; v++) begin
      string tg;
      tg = !VECS[v].fwd ? "R3" : (VECS[v].space == 2'd0 ? "R1" : "R2");
      run_xfer(VECS[v].we, VECS[v].addr, VECS[v].wdata, VECS[v].crd, 0,
               fwd, sp, ofs, cwe, cwd, rd, rqd, rdyb);
      check(tg, $sformatf("vec%0d forwarded", v), fwd, VECS[v].fwd);
      check("R5", $sformatf("vec%0d read data", v), rd, VECS[v].rdata);
      if (VECS[v].fwd) begin
        check(tg, $sformatf("vec%0d space", v), sp, VECS[v].space);
        check(tg, $sformatf("vec%0d offset", v), ofs, VECS[v].ofs);
        check(tg, $sformatf("vec%0d we", v), cwe, VECS[v].we);
        if (VECS[v].we) check(tg, $sformatf("vec%0d wdata", v), cwd, VECS[v].wdata);
        check("R5", $sformatf("vec%0d ready while busy", v), rdyb, 0);
      end
    end

    // interrupt pass-through
    card_irq_i = 1;
    @(negedge clk);
    check("R10", "host_irq follows high", host_irq_o, 1);
    check("R10", "no-irq variant low", n_irq, 0);
    card_irq_i = 0;
    @(negedge clk);
    check("R10", "host_irq follows low", host_irq_o, 0);
    card_irq_i = 1;
    @(negedge clk);

    do_ctl(0, 1);
    check("R9", "eject ack ok", ctl_err_o, 0);
    check("R9", "eject detach", detach_o, 1);
    check("R9", "eject present", present_o, 0);
    check("R9", "eject cd_irq", cd_irq_o, 0);
    check("R9", "eject host_irq", host_irq_o, 0);
    @(negedge clk);
    check("R9", "host_irq stays low", host_irq_o, 0);
    card_irq_i = 0;

    // eject while card holds off its response
    do_ctl(1, 0);
    run_xfer(0, 28'h800_0010, 0, 32'h0000_0077, 1, fwd, sp, ofs, cwe, cwd, rd, rqd, rdyb);
    check("R11", "abort forwarded first", fwd, 1);
    check("R11", "abort read data", rd, 0);
    check("R11", "abort card_req dropped", rqd, 0);
    check("R11", "abort present", present_o, 0);

    run_xfer(0, 28'h000_0020, 0, 32'h0000_0099, 0, fwd, sp, ofs, cwe, cwd, rd, rqd, rdyb);
    check("R4", "after eject not forwarded", fwd, 0);
    check("R4", "after eject read zero", rd, 0);

    // simultaneous requests
    do_ctl(1, 1);
    check("R12", "both on empty err", ctl_err_o, 0);
    check("R12", "both on empty present", present_o, 1);
    check("R12", "both on empty detach", detach_o, 0);
    do_ctl(1, 1);
    check("R12", "both on present err", ctl_err_o, 1);
    check("R12", "both on present stays", present_o, 1);
    check("R12", "both on present detach", detach_o, 0);

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule